// File: doc/BRIEF.md
# Variable-Length Unsigned Dot Product

This block forms the dot product of two vectors of up to eight unsigned 8-bit elements. The vectors arrive as two packed 64-bit buses. A 3-bit length code chooses how many leading element pairs take part, and the sum appears on a 32-bit output. There is no clock: the output follows the inputs combinationally.

Every product is formed in parallel and fed into a chain of running sums, one per element position. The running sum for position i holds the total of the products at positions 0 to i. The length code does not bound a loop. It only drives a multiplexer that picks one of these running sums, so the logic has a fixed shape whatever the code. Because code 0 would otherwise be unused, it stands for the full eight-element length.

Top module: `dotp_var_len`

## Requirements
- R1: For a length code L from 1 to 7, sum_o equals the sum of a[i]*b[i] for i from 0 to L-1.
- R2: Length code 0 selects all eight element pairs, indices 0 to 7.
- R3: Elements and products are unsigned. Each 16-bit product is zero-extended to 32 bits before it is added, and no input can overflow the result. All elements 0xFF with code 0 gives 520200.
- R4: Elements at indices at or above the selected length have no effect on sum_o.
- R5: Element i of each vector sits in bits [8*i+7:8*i] of its bus, so element 0 is in bits [7:0].
- R6: The output depends only on the present inputs. No value is kept from an earlier input pattern.
- R7: For fixed vectors, sum_o never decreases as the selected length grows from 1 through 7 to the full length (code 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_a_i | input | 64 | First vector, element i in bits [8i+7:8i] |
| vec_b_i | input | 64 | Second vector, same layout as vec_a_i |
| len_i | input | 3 | Number of leading pairs to use; 0 means all eight |
| sum_o | output | 32 | Unsigned sum of the selected products |

## Verification
The block holds no state, so a fault in one product, one running-sum stage or the selector shows at sum_o in the same evaluation as the input that exercises it. A wrong product or sum stage at index k corrupts every length at or above k+1 and leaves shorter lengths correct. A wrong select decode corrupts only the codes it maps wrongly. The bench sweeps every length code against arithmetic reference sums, fills the elements beyond the length with noise, and sweeps one element pair exhaustively.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int unsigned N_ELEM = 8;
  localparam int unsigned ELEM_W = 8;
  localparam int unsigned SUM_W  = 32;
  localparam int unsigned LEN_W  = $clog2(N_ELEM);
  localparam int unsigned PROD_W = 2 * ELEM_W;
endpackage

// File: rtl/dotp_mul_array.sv
module dotp_mul_array #(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned ELEM_W = 8,
  localparam int unsigned PROD_W = 2 * ELEM_W
) (
  input  logic [N_ELEM*ELEM_W-1:0]    vec_a_i,
  input  logic [N_ELEM*ELEM_W-1:0]    vec_b_i,
  output logic [N_ELEM-1:0][PROD_W-1:0] prod_o
);
  for (genvar i = 0; i < N_ELEM; i++) begin : g_mul
    logic [ELEM_W-1:0] a_el, b_el;
    assign a_el = vec_a_i[i*ELEM_W +: ELEM_W];
    assign b_el = vec_b_i[i*ELEM_W +: ELEM_W];
    assign prod_o[i] = PROD_W'(a_el) * PROD_W'(b_el);
  end
endmodule

// File: rtl/dotp_psum_chain.sv
module dotp_psum_chain #(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned PROD_W = 16,
  parameter int unsigned SUM_W  = 32
) (
  input  logic [N_ELEM-1:0][PROD_W-1:0] prod_i,
  output logic [N_ELEM-1:0][SUM_W-1:0]  psum_o
);
  localparam int unsigned PAD_W = SUM_W - PROD_W;

  always_comb begin
    psum_o[0] = {{PAD_W{1'b0}}, prod_i[0]};
    for (int i = 1; i < N_ELEM; i++) begin
      psum_o[i] = psum_o[i-1] + {{PAD_W{1'b0}}, prod_i[i]};
    end
  end

  // each stage adds a non-negative term to the one before
  always_comb begin
    for (int i = 1; i < N_ELEM; i++) begin
      if (!$isunknown({psum_o[i], psum_o[i-1]}))
        AST_CHAIN_MONO: assert (psum_o[i] >= psum_o[i-1]); // R7
    end
  end
endmodule

// File: rtl/dotp_len_mux.sv
module dotp_len_mux #(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [N_ELEM-1:0][SUM_W-1:0] psum_i,
  input  logic [LEN_W-1:0]             len_i,
  output logic [SUM_W-1:0]             sum_o
);
  localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(N_ELEM - 1);

  logic [LEN_W-1:0] sel;

  // code 0 reaches the full length
  always_comb begin
    if (len_i == '0) sel = LAST_IDX;
    else             sel = len_i - LEN_W'(1);
  end

  assign sum_o = psum_i[sel];

  always_comb begin
    if (!$isunknown(len_i) && len_i == '0 && !$isunknown(psum_i[N_ELEM-1]))
      AST_LEN0_FULL: assert (sum_o == psum_i[N_ELEM-1]); // R2
  end
endmodule

// File: rtl/dotp_var_len.sv
module dotp_var_len
  import dotp_pkg::*;
(
  input  logic [N_ELEM*ELEM_W-1:0] vec_a_i,
  input  logic [N_ELEM*ELEM_W-1:0] vec_b_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [SUM_W-1:0]         sum_o
);
  localparam logic [63:0] ELEM_MAX = 64'((1 << ELEM_W) - 1);
  localparam logic [63:0] MAX_SUM  = 64'(N_ELEM) * ELEM_MAX * ELEM_MAX;

  logic [N_ELEM-1:0][PROD_W-1:0] prod;
  logic [N_ELEM-1:0][SUM_W-1:0]  psum;

  dotp_mul_array #(
    .N_ELEM (N_ELEM),
    .ELEM_W (ELEM_W)
  ) u_mul (
    .vec_a_i (vec_a_i),
    .vec_b_i (vec_b_i),
    .prod_o  (prod)
  );

  dotp_psum_chain #(
    .N_ELEM (N_ELEM),
    .PROD_W (PROD_W),
    .SUM_W  (SUM_W)
  ) u_chain (
    .prod_i (prod),
    .psum_o (psum)
  );

  dotp_len_mux #(
    .N_ELEM (N_ELEM),
    .SUM_W  (SUM_W),
    .LEN_W  (LEN_W)
  ) u_mux (
    .psum_i (psum),
    .len_i  (len_i),
    .sum_o  (sum_o)
  );

  always_comb begin
    if (!$isunknown(sum_o))
      AST_NO_OVERFLOW: assert (64'(sum_o) <= MAX_SUM); // R3
    if (!$isunknown({len_i, sum_o, prod[0]}) && len_i == LEN_W'(1))
      AST_LEN1_FIRST: assert (sum_o == SUM_W'(prod[0])); // R1 R4
  end
endmodule

// File: tb/dotp_var_len_bench.sv
module dotp_var_len_bench;
  localparam int NE = 8;
  localparam int EW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NE*EW-1:0] vec_a, vec_b;
  logic [2:0]       len;
  logic [31:0]      sum;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dotp_var_len u_dotp_var_len (
    .vec_a_i (vec_a),
    .vec_b_i (vec_b),
    .len_i   (len),
    .sum_o   (sum)
  );

  function automatic int unsigned eff_len(input logic [2:0] l);
    return (l == 3'd0) ? NE : int'(l);
  endfunction

  function automatic logic [31:0] ref_sum(input logic [NE*EW-1:0] a,
                                          input logic [NE*EW-1:0] b,
                                          input logic [2:0] l);
    logic [31:0] acc = 32'd0;
    for (int i = 0; i < NE; i++)
      if (i < int'(eff_len(l)))
        acc += 32'(a[i*EW +: EW]) * 32'(b[i*EW +: EW]);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_chk++;
    if (sum !== exp) begin
      n_bad++;
      $display("FAIL %s: len=%0d got=%0d exp=%0d", tag, len, sum, exp);
    end
  endtask

  task automatic apply(input logic [NE*EW-1:0] a, input logic [NE*EW-1:0] b,
                       input logic [2:0] l);
    @(negedge clk);
    vec_a = a;
    vec_b = b;
    len   = l;
    #1;
  endtask

  initial begin
    logic [NE*EW-1:0] a, b, ma, mb;
    logic [31:0] prev;
    vec_a = '0; vec_b = '0; len = '0;
    #1;
    apply('0, '0, 3'd0);
    check("R6 zero inputs", 32'd0);

    // R3: all 0xFF, every length
    for (int l = 0; l < 8; l++) begin
      apply({NE*EW{1'b1}}, {NE*EW{1'b1}}, 3'(l));
      check(l == 0 ? "R2 R3 all-ff full" : "R3 all-ff", 32'(eff_len(3'(l))) * 32'd65025);
    end

    // R1 R5: ramp, element i = i+1 on a, 2 on b
    for (int i = 0; i < NE; i++) begin
      a[i*EW +: EW] = 8'(i + 1);
      b[i*EW +: EW] = 8'd2;
    end
    for (int l = 1; l < 8; l++) begin
      apply(a, b, 3'(l));
      check("R1 R5 ramp", 32'(l * (l + 1)));
    end
    apply(a, b, 3'd0);
    check("R2 ramp full", 32'd72);

    // R5: single element set at each position
    for (int i = 0; i < NE; i++) begin
      a = '0; b = '0;
      a[i*EW +: EW] = 8'd3;
      b[i*EW +: EW] = 8'd5;
      apply(a, b, 3'd0);
      check("R5 position", 32'd15);
      if (i > 0) begin
        apply(a, b, 3'(i));
        check("R4 beyond length", 32'd0);
      end
    end

    // R1 R4 R6 R7: random vectors, noise beyond length
    for (int t = 0; t < 400; t++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      prev = 32'd0;
      for (int l = 1; l <= NE; l++) begin
        ma = a; mb = b;
        for (int i = l; i < NE; i++) begin
          ma[i*EW +: EW] = 8'($urandom);
          mb[i*EW +: EW] = 8'($urandom);
        end
        apply(ma, mb, 3'(l % 8));
        check("R1 R4 random", ref_sum(a, b, 3'(l % 8)));
        n_chk++;
        if (sum < prev) begin
          n_bad++;
          $display("FAIL R7 monotonic: got=%0d exp>=%0d", sum, prev);
        end
        prev = sum;
      end
    end

    // R6: alternating patterns leave no trace
    for (int t = 0; t < 20; t++) begin
      apply({NE*EW{1'b1}}, {NE*EW{1'b1}}, 3'd0);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      apply(a, b, 3'd4);
      check("R6 no memory", ref_sum(a, b, 3'd4));
    end

    // R1 R3: exhaustive first pair, length 1, noise elsewhere
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        a[EW-1:0] = 8'(x);
        b[EW-1:0] = 8'(y);
        apply(a, b, 3'd1);
        check("R1 R3 pair0", 32'(x * y));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule